// File: doc/BRIEF.md
# Dual-Tap Frame Reassembly Address Generator

This block turns the position of a pixel inside one of two camera data streams into its linear address in the assembled frame buffer. Each pixel arrives with the stream it came from, its row and column inside that stream, the frame width and height, a layout control and a geometry mode. The block returns the frame address one cycle later on a valid/ready output. Whatever sits downstream uses that address to place the pixel.

Reassembly is on only when the layout control equals 2. At any other layout value the stream select and the geometry mode have no effect, and the pixel's row and column map straight onto one linear frame. With reassembly on, the geometry mode picks how the two streams are merged. Mode 1 interlaces lines. Mode 2 stacks the streams top over bottom. Modes 3, 4 and 5 place the streams side by side, and in modes 4 and 5 one half arrives in reversed horizontal order and is mirrored on write.

Top module: `tapMergeAddrGen`

## Requirements
- R1: During and after reset, `outValid` and `modeErr` are 0 until a pixel or a configuration sets them.
- R2: When `layoutCtl` is not 2, the address is `inRow*frameWidth + inCol`, whatever the values of `inStream` and `geomMode`.
- R3: When `layoutCtl` is 2 and `geomMode` is 1 (interlaced), the destination row is `2*inRow + inStream` and the column is `inCol`. Stream 0 holds the odd lines when counting from 1.
- R4: When `layoutCtl` is 2 and `geomMode` is 2 (top/bottom), the destination row is `inRow + inStream*(frameHeight/2)` and the column is `inCol`.
- R5: When `layoutCtl` is 2 and `geomMode` is 3 (side by side, both halves scanned forward), the row is `inRow` and the column is `inCol + inStream*(frameWidth/2)`.
- R6: When `layoutCtl` is 2 and `geomMode` is 4, stream 0 is written at column `inCol`. Stream 1 is mirrored at column `frameWidth/2 + (frameWidth/2 - 1 - inCol)`.
- R7: When `layoutCtl` is 2 and `geomMode` is 5, stream 0 is mirrored at column `frameWidth/2 - 1 - inCol`. Stream 1 is written at column `frameWidth/2 + inCol`.
- R8: When `layoutCtl` is 2 and `geomMode` is 0, 6 or 7, an offered pixel is still accepted, but `outValid` stays 0. `modeErr` reads 1 one cycle after such a configuration is present and reads 0 one cycle after a legal one.
- R9: A pixel accepted at a clock edge (`inValid` and `inReady` both 1) is shown on `outValid`/`outAddr` directly after that edge. This is one cycle of latency.
- R10: While `outValid` is 1 and `outReady` is 0, `inReady` is 0 and both `outValid` and `outAddr` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| layoutCtl | input | 2 | Layout control; 2 turns on two-stream reassembly |
| geomMode | input | 3 | Geometry mode, legal values 1 to 5 |
| frameWidth | input | WB | Assembled frame width in pixels (even) |
| frameHeight | input | HB | Assembled frame height in lines (even) |
| inValid | input | 1 | Input pixel position valid |
| inReady | output | 1 | Block can accept a pixel position |
| inStream | input | 1 | Source stream (0 or 1) |
| inRow | input | HB | Row within the source stream |
| inCol | input | WB | Column within the source stream, in scan order |
| outValid | output | 1 | Destination address valid |
| outReady | input | 1 | Downstream accepts the address |
| outAddr | output | WB+HB | Linear pixel address in the assembled frame |
| modeErr | output | 1 | Illegal geometry mode while reassembly is on |

## Verification
A wrong row or column selection appears as a wrong `outAddr` in the cycle after the pixel is accepted. Mirror errors show most clearly at the first and last column of a half, so the bench drives those edges as well as random positions in every mode. A handshake register stuck in the wrong state shows up within one cycle. It either drops or duplicates an address under backpressure, or lets `outValid` rise for an illegal mode, and the bench observes both cases at the ports.

// File: rtl/tapMergePkg.sv
package tapMergePkg;

  localparam logic [1:0] LAYOUT_MERGE = 2'd2;

  localparam logic [2:0] GEOM_INTERLACE    = 3'd1;
  localparam logic [2:0] GEOM_STACK        = 3'd2;
  localparam logic [2:0] GEOM_SIDE         = 3'd3;
  localparam logic [2:0] GEOM_MIRROR_RIGHT = 3'd4;
  localparam logic [2:0] GEOM_MIRROR_LEFT  = 3'd5;

  typedef enum logic [1:0] {
    ROW_DIRECT     = 2'd0,
    ROW_INTERLEAVE = 2'd1,
    ROW_STACK      = 2'd2
  } rowKind_e;

  typedef enum logic [1:0] {
    COL_DIRECT    = 2'd0,
    COL_SHIFT     = 2'd1,
    COL_MIRROR_HI = 2'd2,
    COL_MIRROR_LO = 2'd3
  } colKind_e;

  typedef struct packed {
    logic     capture;
    rowKind_e rowKind;
    colKind_e colKind;
  } ctrlStrobe_t;

endpackage

// File: rtl/tapMergeCtrl.sv
module tapMergeCtrl
  import tapMergePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  layoutCtl,
  input  logic [2:0]  geomMode,
  input  logic        inValid,
  output logic        inReady,
  output logic        outValid,
  input  logic        outReady,
  output logic        modeErr,
  output ctrlStrobe_t strobe
);

  logic mergeOn;
  logic modeOk;
  logic legal;
  logic accept;
  logic validQ;
  logic errQ;

  always_comb begin
    mergeOn = (layoutCtl == LAYOUT_MERGE);
    modeOk  = (geomMode >= GEOM_INTERLACE) && (geomMode <= GEOM_MIRROR_LEFT);
    legal   = !mergeOn || modeOk;
  end

  assign inReady = !validQ || outReady;
  assign accept  = inValid && inReady;

  always_comb begin
    strobe.capture = accept && legal;
    strobe.rowKind = ROW_DIRECT;
    strobe.colKind = COL_DIRECT;
    if (mergeOn) begin
      unique case (geomMode)
        GEOM_INTERLACE:    strobe.rowKind = ROW_INTERLEAVE;
        GEOM_STACK:        strobe.rowKind = ROW_STACK;
        GEOM_SIDE:         strobe.colKind = COL_SHIFT;
        GEOM_MIRROR_RIGHT: strobe.colKind = COL_MIRROR_HI;
        GEOM_MIRROR_LEFT:  strobe.colKind = COL_MIRROR_LO;
        default: begin
          strobe.rowKind = ROW_DIRECT;
          strobe.colKind = COL_DIRECT;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      errQ <= !legal;
      if (accept) begin
        validQ <= legal;
      end else if (outReady) begin
        validQ <= 1'b0;
      end
    end
  end

  assign outValid = validQ;
  assign modeErr  = errQ;

  // R10
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

  // R10
  no_accept_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  // R9
  legal_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && (layoutCtl != LAYOUT_MERGE)) |=> outValid);

  // R8
  illegal_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && (layoutCtl == LAYOUT_MERGE) &&
     ((geomMode == 3'd0) || (geomMode > GEOM_MIRROR_LEFT))) |=> (!outValid && modeErr));

endmodule

// File: rtl/tapMergeCoordMap.sv
module tapMergeCoordMap
  import tapMergePkg::*;
#(
  parameter int WB = 12,
  parameter int HB = 12
) (
  input  rowKind_e        rowKind,
  input  colKind_e        colKind,
  input  logic            inStream,
  input  logic [HB-1:0]   inRow,
  input  logic [WB-1:0]   inCol,
  input  logic [WB-1:0]   frameWidth,
  input  logic [HB-1:0]   frameHeight,
  output logic [HB-1:0]   dstRow,
  output logic [WB-1:0]   dstCol
);

  logic [WB-1:0] halfW;
  logic [HB-1:0] halfH;
  logic [WB-1:0] mirrorCol;

  always_comb begin
    halfW     = frameWidth >> 1;
    halfH     = frameHeight >> 1;
    mirrorCol = halfW - WB'(1) - inCol;
  end

  always_comb begin
    unique case (rowKind)
      ROW_INTERLEAVE: dstRow = (inRow << 1) | HB'(inStream);
      ROW_STACK:      dstRow = inRow + (inStream ? halfH : '0);
      default:        dstRow = inRow;
    endcase
  end

  always_comb begin
    unique case (colKind)
      COL_SHIFT:     dstCol = inCol + (inStream ? halfW : '0);
      COL_MIRROR_HI: dstCol = inStream ? (halfW + mirrorCol) : inCol;
      COL_MIRROR_LO: dstCol = inStream ? (halfW + inCol) : mirrorCol;
      default:       dstCol = inCol;
    endcase
  end

endmodule

// File: rtl/tapMergeDatapath.sv
module tapMergeDatapath
  import tapMergePkg::*;
#(
  parameter int WB = 12,
  parameter int HB = 12,
  localparam int AW = WB + HB
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobe_t   strobe,
  input  logic          inStream,
  input  logic [HB-1:0] inRow,
  input  logic [WB-1:0] inCol,
  input  logic [WB-1:0] frameWidth,
  input  logic [HB-1:0] frameHeight,
  output logic [AW-1:0] outAddr
);

  logic [HB-1:0] dstRow;
  logic [WB-1:0] dstCol;
  logic [AW-1:0] rowBase;
  logic [AW-1:0] addrNext;
  logic [AW-1:0] addrQ;

  tapMergeCoordMap #(.WB(WB), .HB(HB)) uMap (
    .rowKind     (strobe.rowKind),
    .colKind     (strobe.colKind),
    .inStream    (inStream),
    .inRow       (inRow),
    .inCol       (inCol),
    .frameWidth  (frameWidth),
    .frameHeight (frameHeight),
    .dstRow      (dstRow),
    .dstCol      (dstCol)
  );

  always_comb begin
    rowBase  = AW'(dstRow) * AW'(frameWidth);
    addrNext = rowBase + AW'(dstCol);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (strobe.capture) begin
      addrQ <= addrNext;
    end
  end

  assign outAddr = addrQ;

endmodule

// File: rtl/tapMergeAddrGen.sv
module tapMergeAddrGen
  import tapMergePkg::*;
#(
  parameter int WB = 12,
  parameter int HB = 12,
  localparam int AW = WB + HB
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    layoutCtl,
  input  logic [2:0]    geomMode,
  input  logic [WB-1:0] frameWidth,
  input  logic [HB-1:0] frameHeight,
  input  logic          inValid,
  output logic          inReady,
  input  logic          inStream,
  input  logic [HB-1:0] inRow,
  input  logic [WB-1:0] inCol,
  output logic          outValid,
  input  logic          outReady,
  output logic [AW-1:0] outAddr,
  output logic          modeErr
);

  ctrlStrobe_t strobe;

  tapMergeCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .layoutCtl (layoutCtl),
    .geomMode  (geomMode),
    .inValid   (inValid),
    .inReady   (inReady),
    .outValid  (outValid),
    .outReady  (outReady),
    .modeErr   (modeErr),
    .strobe    (strobe)
  );

  tapMergeDatapath #(.WB(WB), .HB(HB)) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .inStream    (inStream),
    .inRow       (inRow),
    .inCol       (inCol),
    .frameWidth  (frameWidth),
    .frameHeight (frameHeight),
    .outAddr     (outAddr)
  );

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outAddr));

  // R2
  pass_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && (layoutCtl != LAYOUT_MERGE)) |=>
      (outAddr == $past(AW'(inRow) * AW'(frameWidth) + AW'(inCol))));

endmodule

// File: tb/tb_tapMergeAddrGen.sv
module tb_tapMergeAddrGen;

  localparam int WB = 12;
  localparam int HB = 12;
  localparam int AW = WB + HB;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    layoutCtl = 2'd0;
  logic [2:0]    geomMode = 3'd1;
  logic [WB-1:0] frameWidth = WB'(16);
  logic [HB-1:0] frameHeight = HB'(8);
  logic          inValid = 1'b0;
  logic          inReady;
  logic          inStream = 1'b0;
  logic [HB-1:0] inRow = '0;
  logic [WB-1:0] inCol = '0;
  logic          outValid;
  logic          outReady = 1'b1;
  logic [AW-1:0] outAddr;
  logic          modeErr;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tapMergeAddrGen #(.WB(WB), .HB(HB)) dut (
    .clk(clk), .rstN(rstN), .layoutCtl(layoutCtl), .geomMode(geomMode),
    .frameWidth(frameWidth), .frameHeight(frameHeight),
    .inValid(inValid), .inReady(inReady), .inStream(inStream),
    .inRow(inRow), .inCol(inCol), .outValid(outValid), .outReady(outReady),
    .outAddr(outAddr), .modeErr(modeErr)
  );

  function automatic int expAddr(int lay, int md, int w, int h, int s, int r, int c);
    int hw = w / 2;
    int hh = h / 2;
    int row = r;
    int col = c;
    if (lay == 2) begin
      case (md)
        1: row = 2 * r + s;
        2: row = r + s * hh;
        3: col = c + s * hw;
        4: col = (s == 1) ? hw + (hw - 1 - c) : c;
        5: col = (s == 1) ? hw + c : hw - 1 - c;
        default: ;
      endcase
    end
    return row * w + col;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sendOne(input int s, input int r, input int c, input string tag);
    int e;
    @(negedge clk);
    inStream = s[0];
    inRow = HB'(r);
    inCol = WB'(c);
    inValid = 1'b1;
    e = expAddr(layoutCtl, geomMode, frameWidth, frameHeight, s, r, c);
    @(posedge clk);
    #2;
    check(outValid == 1'b1, {tag, " valid"}, outValid, 1);
    check(outAddr == AW'(e), tag, outAddr, e);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic randomPixel(input int md, input string tag);
    int s = $urandom_range(0, 1);
    int rmax = (md == 1 || md == 2) ? frameHeight / 2 - 1 : frameHeight - 1;
    int cmax = (md >= 3) ? frameWidth / 2 - 1 : frameWidth - 1;
    sendOne(s, $urandom_range(0, rmax), $urandom_range(0, cmax), tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(posedge clk);
    #2;
    // R1
    check(outValid == 1'b0, "R1 reset valid", outValid, 0);
    check(modeErr == 1'b0, "R1 reset err", modeErr, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #2;
    check(outValid == 1'b0, "R1 idle valid", outValid, 0);

    // R2 passthrough, stream and mode ignored
    layoutCtl = 2'd0; geomMode = 3'd4;
    sendOne(1, 3, 5, "R2 layout0");
    layoutCtl = 2'd3; geomMode = 3'd6;
    sendOne(1, 7, 15, "R2 layout3 mode6");
    @(posedge clk); #2;
    check(modeErr == 1'b0, "R2 no err", modeErr, 0);

    layoutCtl = 2'd2;
    // directed corners, width 16 height 8
    geomMode = 3'd1;
    sendOne(0, 0, 0, "R3 first odd line");
    sendOne(1, 3, 15, "R3 last even line");
    geomMode = 3'd2;
    sendOne(1, 0, 0, "R4 bottom start");
    sendOne(0, 3, 15, "R4 top end");
    geomMode = 3'd3;
    sendOne(1, 0, 0, "R5 right start");
    geomMode = 3'd4;
    sendOne(1, 0, 0, "R6 mirror right edge");
    sendOne(1, 2, 7, "R6 mirror centre");
    sendOne(0, 2, 7, "R6 direct left");
    geomMode = 3'd5;
    sendOne(0, 0, 0, "R7 mirror centre");
    sendOne(0, 1, 7, "R7 mirror left edge");
    sendOne(1, 1, 7, "R7 direct right");

    // random frames and pixels per mode
    for (int f = 0; f < 12; f++) begin
      frameWidth = WB'(2 * $urandom_range(2, 60));
      frameHeight = HB'(2 * $urandom_range(1, 30));
      for (int m = 1; m <= 5; m++) begin
        geomMode = 3'(m);
        for (int k = 0; k < 6; k++) begin
          case (m)
            1: randomPixel(m, "R3 random");
            2: randomPixel(m, "R4 random");
            3: randomPixel(m, "R5 random");
            4: randomPixel(m, "R6 random");
            default: randomPixel(m, "R7 random");
          endcase
        end
      end
      layoutCtl = 2'd1;
      randomPixel(0, "R2 random");
      layoutCtl = 2'd2;
    end

    // R10 backpressure
    frameWidth = WB'(20); frameHeight = HB'(10); geomMode = 3'd3;
    @(negedge clk);
    outReady = 1'b0;
    inStream = 1'b1; inRow = HB'(2); inCol = WB'(4); inValid = 1'b1;
    @(posedge clk); #2;
    // R9
    check(outValid == 1'b1, "R9 latency", outValid, 1);
    check(outAddr == AW'(54), "R9 addr", outAddr, 54);
    @(negedge clk);
    inStream = 1'b0; inRow = HB'(1); inCol = WB'(3);
    repeat (3) begin
      @(posedge clk); #2;
      check(inReady == 1'b0, "R10 inReady low", inReady, 0);
      check(outValid == 1'b1 && outAddr == AW'(54), "R10 hold", outAddr, 54);
    end
    @(negedge clk);
    outReady = 1'b1;
    @(posedge clk); #2;
    check(outAddr == AW'(23), "R10 next after release", outAddr, 23);
    @(negedge clk);
    inValid = 1'b0;
    @(posedge clk); #2;
    check(outValid == 1'b0, "R10 drain", outValid, 0);

    // R8 illegal modes
    for (int i = 0; i < 3; i++) begin
      int bad = (i == 0) ? 0 : ((i == 1) ? 6 : 7);
      @(negedge clk);
      geomMode = 3'(bad);
      inValid = 1'b1; inStream = 1'b0; inRow = '0; inCol = '0;
      #1;
      check(inReady == 1'b1, "R8 accepted", inReady, 1);
      @(posedge clk); #2;
      check(outValid == 1'b0, "R8 no valid", outValid, 0);
      check(modeErr == 1'b1, "R8 err set", modeErr, 1);
      @(negedge clk);
      inValid = 1'b0;
    end
    @(negedge clk);
    geomMode = 3'd2;
    @(posedge clk); #2;
    check(modeErr == 1'b0, "R8 err clear", modeErr, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule